// File: doc/BRIEF.md
# Per-Pin GPIO Controller with Field Write-Enables

This block controls a parameterised number of general-purpose pins. Each pin has its own 32-bit configuration word on a simple memory-mapped bus. Every configurable field in that word sits next to a guard bit, and a write changes the field only when its guard bit is set in the same write. Software can therefore change one field of one pin in a single write, without reading the word first.

Each pad input passes through a two-stage synchronizer and then a debounce filter. The filter's hold time comes from a 3-bit selector and is measured in microsecond ticks from an internal prescaler. The filtered level can be read back, and it drives three shared status vectors with one bit per pin:
- a set-on-entry vector, for transitions into the active level;
- a set-on-exit vector, for transitions out of the active level;
- a live level vector.

A single registered interrupt line combines the pending status bits of the pins whose interrupts are enabled.

Top module: `gpio_top`

## Requirements
- R1: After reset every pin word reads 0 (input direction, interrupts off, debounce code 0), every status word reads 0, and `gpio_oe_o`, `gpio_o` and `irq_o` are 0.
- R2: Pin k's word is at byte offset 4*k. Bit 0 sets the direction (1 = output) and appears on `gpio_oe_o[k]`. Bit 2 sets the output value and appears on `gpio_o[k]`.
- R3: A field at bit x (0 direction, 2 output, 6 edge polarity, 8 edge enable, 16 level enable, 18 level polarity) takes the written value only when bit x+1 of the same write is 1; otherwise it keeps its value.
- R4: The debounce code in bits 30:28 changes only when bit 31 of the same write is 1.
- R5: Bit 4 returns the filtered input and ignores writes. All guard-bit positions and unused bits read 0.
- R6: The filtered input takes a new pad level only after that level has been stable for the selected time. Codes 0..7 select 1, 10, 100, 1000, 10000, 20000, 30000 and 50000 microsecond ticks.
- R7: A pad pulse shorter than the selected time leaves the filtered input unchanged, because every return to the filtered level restarts the count.
- R8: With the edge enable set, a filtered transition to the level given by the edge polarity (1 = high) sets the pin's bit in the entry vector. A transition away from that level sets the pin's bit in the exit vector. Pin p sits at bit p%32 of word p/32. The entry, exit and level vectors start at byte offsets 0x200, 0x240 and 0x280 respectively.
- R9: With the edge enable clear, filtered transitions set no status bit.
- R10: Writing 1 to an entry or exit status bit clears it. Writing 0 leaves it unchanged.
- R11: A level status bit is 1 exactly while the pin's level enable is set and its filtered input equals its level polarity. Writes to the level words have no effect.
- R12: `irq_o` is 1 one cycle after any pin has a pending entry or exit bit with its edge enable set, or a set level bit. Clearing the enable or the bit drops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | AW | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with `rvalid_o` |
| rvalid_o | output | 1 | Read data valid, one cycle after `rd_en_i` |
| pad_i | input | NPINS | Raw pad levels |
| gpio_o | output | NPINS | Output values |
| gpio_oe_o | output | NPINS | Output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that the bus never raises a write and a read in the same cycle. They also assume that pad levels change only between clock edges, and that the configuration changes only through bus writes. The stimulus drives all inputs on the falling clock edge and issues one bus operation at a time. Between a pad change and any check that depends on it, the stimulus waits well past the selected debounce window. The timing checks test only that a change has not yet appeared before the minimum window and has appeared after the maximum one, so tick alignment never decides a result.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int FB_DIR  = 0;
  localparam int FB_OUT  = 2;
  localparam int FB_IN   = 4;
  localparam int FB_EPOL = 6;
  localparam int FB_EEN  = 8;
  localparam int FB_LEN  = 16;
  localparam int FB_LPOL = 18;
  localparam int FB_DBLO = 28;
  localparam int FB_DBWE = 31;

  localparam int DB_CW = 16;

  typedef struct packed {
    logic       dir;
    logic       out;
    logic       epol;
    logic       een;
    logic       len;
    logic       lpol;
    logic [2:0] dbsel;
  } pin_cfg_t;

  function automatic logic [DB_CW-1:0] db_limit(input logic [2:0] code);
    logic [DB_CW-1:0] v;
    case (code)
      3'd0:    v = DB_CW'(1);
      3'd1:    v = DB_CW'(10);
      3'd2:    v = DB_CW'(100);
      3'd3:    v = DB_CW'(1000);
      3'd4:    v = DB_CW'(10000);
      3'd5:    v = DB_CW'(20000);
      3'd6:    v = DB_CW'(30000);
      default: v = DB_CW'(50000);
    endcase
    return v;
  endfunction
endpackage

// File: rtl/gpio_tick.sv
module gpio_tick #(
  parameter int CLK_MHZ = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;

  generate
    if (CLK_MHZ <= 1) begin : g_pass
      logic unused_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) unused_q <= 1'b0;
        else        unused_q <= 1'b1;
      end
      assign tick_o = unused_q | 1'b1;
    end else begin : g_div
      logic [CW-1:0] cnt_q, cnt_d;
      logic          wrap;
      always_comb begin
        wrap  = (cnt_q == CW'(CLK_MHZ - 1));
        cnt_d = wrap ? '0 : cnt_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
      assign tick_o = wrap;
    end
  endgenerate
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce
  import gpio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       pad_i,
  input  logic [2:0] sel_i,
  output logic       level_o
);
  logic [1:0]       sync_q;
  logic [DB_CW-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic [DB_CW-1:0] lim;

  always_comb begin
    lim   = db_limit(sel_i);
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (sync_q[1] == lvl_q) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_q >= lim - 1'b1) begin
        lvl_d = sync_q[1];
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pad_i};
      cnt_q  <= cnt_d;
      lvl_q  <= lvl_d;
    end
  end

  assign level_o = lvl_q;
endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
  import gpio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output pin_cfg_t    cfg_o
);
  pin_cfg_t cfg_q, cfg_d;

  function automatic logic guarded(input logic old, input logic [31:0] d, input int pos);
    return d[pos+1] ? d[pos] : old;
  endfunction

  always_comb begin
    cfg_d = cfg_q;
    if (we_i) begin
      cfg_d.dir  = guarded(cfg_q.dir,  wdata_i, FB_DIR);
      cfg_d.out  = guarded(cfg_q.out,  wdata_i, FB_OUT);
      cfg_d.epol = guarded(cfg_q.epol, wdata_i, FB_EPOL);
      cfg_d.een  = guarded(cfg_q.een,  wdata_i, FB_EEN);
      cfg_d.len  = guarded(cfg_q.len,  wdata_i, FB_LEN);
      cfg_d.lpol = guarded(cfg_q.lpol, wdata_i, FB_LPOL);
      if (wdata_i[FB_DBWE]) cfg_d.dbsel = wdata_i[FB_DBLO+2:FB_DBLO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/gpio_top.sv
module gpio_top
  import gpio_pkg::*;
#(
  parameter int NPINS     = 32,
  parameter int CLK_MHZ   = 100,
  parameter int AW        = 10,
  parameter int ENTRY_OFS = 'h200,
  parameter int EXIT_OFS  = 'h240,
  parameter int LEVEL_OFS = 'h280
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             rvalid_o,
  input  logic [NPINS-1:0] pad_i,
  output logic [NPINS-1:0] gpio_o,
  output logic [NPINS-1:0] gpio_oe_o,
  output logic             irq_o
);
  localparam int NW   = (NPINS + 31) / 32;
  localparam int PADW = NW * 32;
  localparam int PW   = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam int WW   = (NW > 1) ? $clog2(NW) : 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  logic tick;
  gpio_tick #(.CLK_MHZ(CLK_MHZ)) u_tick (.clk(clk), .rst_n(rst_ni), .tick_o(tick));

  // address decode
  logic [AW-3:0] widx;
  logic [PW-1:0] pidx;
  logic          pin_hit, ent_hit, ext_hit, lvl_hit;
  logic [WW-1:0] ent_w, ext_w, lvl_w;
  logic [AW-1:0] ent_off, ext_off, lvl_off;

  always_comb begin
    widx    = addr_i[AW-1:2];
    pidx    = widx[PW-1:0];
    pin_hit = int'(widx) < NPINS;
    ent_hit = (int'(addr_i) >= ENTRY_OFS) && (int'(addr_i) < ENTRY_OFS + 4*NW);
    ext_hit = (int'(addr_i) >= EXIT_OFS)  && (int'(addr_i) < EXIT_OFS + 4*NW);
    lvl_hit = (int'(addr_i) >= LEVEL_OFS) && (int'(addr_i) < LEVEL_OFS + 4*NW);
    ent_off = addr_i - AW'(ENTRY_OFS);
    ext_off = addr_i - AW'(EXIT_OFS);
    lvl_off = addr_i - AW'(LEVEL_OFS);
    ent_w   = ent_off[WW+1:2];
    ext_w   = ext_off[WW+1:2];
    lvl_w   = lvl_off[WW+1:2];
  end

  // per-pin configuration and filtering
  pin_cfg_t         cfg_a [NPINS];
  logic [NPINS-1:0] filt, fprev_q, een_v, len_v;
  logic [NPINS-1:0] set_ent, set_ext, lvl_d;

  generate
    for (genvar k = 0; k < NPINS; k++) begin : g_pin
      logic we_k;
      assign we_k = wr_en_i & pin_hit & (widx == (AW-2)'(k));
      gpio_pin_cfg u_cfg (
        .clk(clk), .rst_n(rst_ni), .we_i(we_k), .wdata_i(wdata_i), .cfg_o(cfg_a[k])
      );
      gpio_debounce u_db (
        .clk(clk), .rst_n(rst_ni), .tick_i(tick), .pad_i(pad_i[k]),
        .sel_i(cfg_a[k].dbsel), .level_o(filt[k])
      );
      assign gpio_oe_o[k] = cfg_a[k].dir;
      assign gpio_o[k]    = cfg_a[k].out;
      assign een_v[k]     = cfg_a[k].een;
      assign len_v[k]     = cfg_a[k].len;
      assign set_ent[k]   = cfg_a[k].een & (filt[k] ^ fprev_q[k]) & (filt[k] == cfg_a[k].epol);
      assign set_ext[k]   = cfg_a[k].een & (filt[k] ^ fprev_q[k]) & (filt[k] != cfg_a[k].epol);
      assign lvl_d[k]     = cfg_a[k].len & (filt[k] == cfg_a[k].lpol);
    end
  endgenerate

  // status vectors
  logic [NPINS-1:0] ent_q, ext_q, lvl_q, ent_d, ext_d;
  logic [PADW-1:0]  clr_ent, clr_ext;
  logic             irq_d;

  always_comb begin
    clr_ent = '0;
    clr_ext = '0;
    if (wr_en_i && ent_hit) clr_ent[ent_w*32 +: 32] = wdata_i;
    if (wr_en_i && ext_hit) clr_ext[ext_w*32 +: 32] = wdata_i;
    ent_d = (ent_q & ~clr_ent[NPINS-1:0]) | set_ent;
    ext_d = (ext_q & ~clr_ext[NPINS-1:0]) | set_ext;
    irq_d = (|((ent_q | ext_q) & een_v)) | (|lvl_q);
  end

  // read path
  logic [PADW-1:0] ent_pad, ext_pad, lvl_pad;
  logic [31:0]     rd_d, rdata_q;
  logic            rvalid_q;
  pin_cfg_t        sel_cfg;

  always_comb begin
    ent_pad = PADW'(ent_q);
    ext_pad = PADW'(ext_q);
    lvl_pad = PADW'(lvl_q);
    sel_cfg = cfg_a[pidx];
    rd_d    = '0;
    if (pin_hit) begin
      rd_d[FB_DIR]  = sel_cfg.dir;
      rd_d[FB_OUT]  = sel_cfg.out;
      rd_d[FB_IN]   = filt[pidx];
      rd_d[FB_EPOL] = sel_cfg.epol;
      rd_d[FB_EEN]  = sel_cfg.een;
      rd_d[FB_LEN]  = sel_cfg.len;
      rd_d[FB_LPOL] = sel_cfg.lpol;
      rd_d[FB_DBLO+2:FB_DBLO] = sel_cfg.dbsel;
    end else if (ent_hit) begin
      rd_d = ent_pad[ent_w*32 +: 32];
    end else if (ext_hit) begin
      rd_d = ext_pad[ext_w*32 +: 32];
    end else if (lvl_hit) begin
      rd_d = lvl_pad[lvl_w*32 +: 32];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      fprev_q  <= '0;
      ent_q    <= '0;
      ext_q    <= '0;
      lvl_q    <= '0;
      irq_o    <= 1'b0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      fprev_q  <= filt;
      ent_q    <= ent_d;
      ext_q    <= ext_d;
      lvl_q    <= lvl_d;
      irq_o    <= irq_d;
      rvalid_q <= rd_en_i;
      if (rd_en_i) rdata_q <= rd_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/gpio_top_chk.sv
module gpio_top_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en_i,
  input logic [NPINS-1:0] gpio_oe_o,
  input logic             irq_o,
  input logic             tick,
  input logic [NPINS-1:0] filt,
  input logic [NPINS-1:0] ent_q,
  input logic [NPINS-1:0] ext_q,
  input logic [NPINS-1:0] lvl_q,
  input logic [NPINS-1:0] een_v,
  input logic [NPINS-1:0] len_v
);
  p_dir_needs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(gpio_oe_o));

  p_filter_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (filt != $past(filt)) |-> $past(tick));

  p_edge_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_q & ~$past(ent_q) & ~$past(een_v)) == '0);

  p_exit_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_q & ~$past(ext_q) & ~$past(een_v)) == '0);

  p_level_needs_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q & ~$past(len_v)) == '0);

  p_irq_has_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past((|ent_q) | (|ext_q) | (|lvl_q)));
endmodule

bind gpio_top gpio_top_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .gpio_oe_o(gpio_oe_o), .irq_o(irq_o),
  .tick(tick), .filt(filt), .ent_q(ent_q), .ext_q(ext_q), .lvl_q(lvl_q),
  .een_v(een_v), .len_v(len_v)
);

// File: tb/sim_gpio_top.sv
module sim_gpio_top;
  localparam int NP  = 36;
  localparam int MHZ = 4;
  localparam int AW  = 10;
  localparam int ENT = 'h200;
  localparam int EXT = 'h240;
  localparam int LVL = 'h280;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, wr_en, rd_en, rvalid, irq;
  logic [AW-1:0] addr;
  logic [31:0]   wdata, rdata;
  logic [NP-1:0] pad, gout, goe;

  gpio_top #(.NPINS(NP), .CLK_MHZ(MHZ), .AW(AW), .ENTRY_OFS(ENT), .EXIT_OFS(EXT),
             .LEVEL_OFS(LVL)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .pad_i(pad),
    .gpio_o(gout), .gpio_oe_o(goe), .irq_o(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] q_exp[$];
  string       q_tag[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rst_n && rvalid && q_exp.size() > 0) begin
      logic [31:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check(t, rdata, e);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = AW'(a); rd_en = 1'b1;
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; pad = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    bus_rd(0, 32'h0, "R1 pin0 word");
    bus_rd(4*35, 32'h0, "R1 pin35 word");
    bus_rd(ENT, 32'h0, "R1 entry word0");
    bus_rd(EXT + 4, 32'h0, "R1 exit word1");
    check("R1 oe", 32'(goe), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);

    // R2 direction and output value
    bus_wr(4*3, 32'h0000_000F);
    bus_rd(4*3, 32'h0000_0005, "R2 pin3 word");
    idle(1);
    check("R2 oe pin3", 32'(goe[3]), 32'h1);
    check("R2 out pin3", 32'(gout[3]), 32'h1);

    // R3 guard bits
    bus_wr(4*3, 32'h0000_0000);
    bus_rd(4*3, 32'h0000_0005, "R3 write without guards ignored");
    bus_wr(4*3, 32'h0000_0002);
    bus_rd(4*3, 32'h0000_0004, "R3 direction cleared alone");
    idle(1);
    check("R3 oe pin3 off", 32'(goe[3]), 32'h0);

    // R4 debounce guard
    bus_wr(4*3, 32'h7000_0000);
    bus_rd(4*3, 32'h0000_0004, "R4 code without bit31 ignored");
    bus_wr(4*3, 32'hA000_0000);
    bus_rd(4*3, 32'h2000_0004, "R4 code 2 taken");

    // R5 read-only input, zero guard positions
    bus_wr(4*3, 32'h0000_0030);
    bus_rd(4*3, 32'h2000_0004, "R5 input bit ignores write");
    bus_wr(4*5, 32'hFFFF_FFFF);
    bus_rd(4*5, 32'h7005_0145, "R5 all-ones write readback");
    bus_rd(LVL, 32'h0, "R5 pin5 level off while pad low");
    bus_wr(4*5, 32'h800A_028A);
    bus_rd(4*5, 32'h0, "R5 pin5 cleared");

    // R6 debounce timing, code 1 (10 ticks) on pin0, code 0 on pin1
    bus_wr(0, 32'h9000_0000);
    pad[0] = 1'b1;
    idle(20);
    bus_rd(0, 32'h1000_0000, "R6 pin0 not yet filtered");
    idle(60);
    bus_rd(0, 32'h1000_0010, "R6 pin0 filtered high");
    pad[1] = 1'b1;
    idle(12);
    bus_rd(4, 32'h0000_0010, "R6 pin1 code0 filtered high");

    // R7 short pulse rejected
    pad[0] = 1'b0;
    idle(16);
    pad[0] = 1'b1;
    idle(80);
    bus_rd(0, 32'h1000_0010, "R7 short low pulse rejected");

    // R8 edge status on pin0, polarity high
    bus_wr(0, 32'h0000_03C0);
    pad[0] = 1'b0;
    idle(80);
    bus_rd(EXT, 32'h1, "R8 exit bit pin0");
    bus_rd(ENT, 32'h0, "R8 entry bit pin0 clear");
    check("R12 irq from exit bit", 32'(irq), 32'h1);
    bus_wr(EXT, 32'h1);
    bus_rd(EXT, 32'h0, "R10 exit bit cleared");
    idle(2);
    check("R12 irq dropped after clear", 32'(irq), 32'h0);
    pad[0] = 1'b1;
    idle(80);
    bus_rd(ENT, 32'h1, "R8 entry bit pin0");
    bus_wr(ENT, 32'h0);
    bus_rd(ENT, 32'h1, "R10 zero write keeps bit");
    bus_wr(ENT, 32'h1);
    bus_rd(ENT, 32'h0, "R10 entry bit cleared");

    // R8 packing: pin33, polarity low, code 0
    bus_wr(4*33, 32'h0000_0380);
    pad[33] = 1'b1;
    idle(20);
    bus_rd(EXT + 4, 32'h2, "R8 exit word1 bit1");
    pad[33] = 1'b0;
    idle(20);
    bus_rd(ENT + 4, 32'h2, "R8 entry word1 bit1");
    bus_wr(ENT + 4, 32'h2);
    bus_wr(EXT + 4, 32'h2);
    bus_rd(ENT + 4, 32'h0, "R10 entry word1 cleared");

    // R9 edge disabled on pin1
    pad[1] = 1'b0;
    idle(20);
    bus_rd(ENT, 32'h0, "R9 no entry bit");
    bus_rd(EXT, 32'h0, "R9 no exit bit");
    check("R9 irq low", 32'(irq), 32'h0);

    // R11 level status on pin2, polarity high
    bus_wr(4*2, 32'h000F_0000);
    idle(4);
    bus_rd(LVL, 32'h0, "R11 level low while pad low");
    pad[2] = 1'b1;
    idle(20);
    bus_rd(LVL, 32'h4, "R11 level set");
    check("R12 irq from level", 32'(irq), 32'h1);
    bus_wr(LVL, 32'h4);
    bus_rd(LVL, 32'h4, "R11 level write ignored");
    bus_wr(4*2, 32'h0002_0000);
    bus_rd(LVL, 32'h0, "R11 level off with enable");
    idle(2);
    check("R12 irq off after level disable", 32'(irq), 32'h0);

    // R12 pending bit masked by edge enable
    pad[0] = 1'b0;
    idle(80);
    check("R12 irq from pin0 exit", 32'(irq), 32'h1);
    bus_wr(0, 32'h0000_0200);
    idle(3);
    check("R12 irq masked by enable", 32'(irq), 32'h0);
    bus_rd(EXT, 32'h1, "R12 status kept while masked");
    bus_wr(EXT, 32'h1);
    bus_rd(EXT, 32'h0, "R10 final clear");

    idle(4);
    if (q_exp.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R1 read responses missing actual=%0d expected=0", q_exp.size());
    end
    done = 1;
    summary();
    $finish;
  end
endmodule